// File: doc/BRIEF.md
# Write-Through Set-Associative Data Cache

This block sits between a load/store port and a word-wide memory port. It splits each byte address into a line offset, a set index and a tag. Byte, halfword and word loads that hit are served from a small data array without any memory traffic. A load miss brings in the whole line. The fill starts at the word that holds the requested address and wraps around inside the aligned line. Each way carries a small age counter. The way with the smallest counter is replaced on a miss, and ties go to the lowest way number.

Every store is written through to memory at its own width. When the memory write succeeds and the cache is in use, a store that hits merges its bytes into the cached word. A store that misses allocates the line with the same wrapped fill that a load uses. The bypass path sends an access straight to memory and leaves the arrays alone. It is taken when the cache is absent, when it is disabled, or when the request is marked cache-inhibited. If the memory reports an error during a fill, the fill is abandoned and the chosen way is invalidated.

Top module: `wt_dcache`

## Requirements
- R1: Set index is address bits [OFFW+SETW-1:OFFW] and tag is the bits above them (OFFW = log2 line bytes, SETW = log2 sets). Lines with equal index and different tags live in different ways of one set, and lines in other sets do not disturb them.
- R2: A load with `cache_present` low, `cache_enable` low or `req_inhibit` high makes one memory read at its own width. It returns the memory value and neither reads nor changes the tag, age or data arrays.
- R3: `req_size` encodes 0 = byte, 1 = halfword, 2 = word, and accesses are naturally aligned. Load data is the addressed bytes moved down to bit 0 and zero-extended. For a store, `req_wdata` holds the value in its low bits.
- R4: A load that hits makes no memory access and returns the cached bytes.
- R5: A miss issues LINE_BYTES/4 word reads. The first read is at the word holding the request address, and the following reads step by 4 and wrap within the aligned line.
- R6: On a miss the victim is the way with the smallest age counter, lowest index on a tie. A way that hits or completes a fill gets its counter set to NWAYS-1, and every other non-zero counter in the set is decremented.
- R7: An error reported during a fill ends the fill without further reads. The victim way is invalidated and its counter cleared, and the response data is 0.
- R8: Every store makes exactly one memory write with `mem_size` equal to the request size and the data placed on byte lanes `mem_addr[1:0]` upward.
- R9: A store that hits after a good memory write merges its bytes into the cached word without any memory read.
- R10: A store that misses after a good memory write allocates the line with the same victim choice and wrapped fill as a load miss.
- R11: A bypassed store, or a store whose memory write reports an error, only writes memory (or nothing). The cache contents are unchanged.
- R12: `req_ready` is high only while idle, and no memory request is made while idle. Each accepted request yields exactly one single-cycle `rsp_valid` pulse (`rsp_rdata` is 0 for stores).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cache_present | input | 1 | Cache is built in and may be used |
| cache_enable | input | 1 | Cache enabled by the processor |
| req_valid | input | 1 | Load/store request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_inhibit | input | 1 | Per-access cache-inhibit |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data, low-justified |
| rsp_valid | output | 1 | Request complete (one cycle) |
| rsp_rdata | output | 32 | Load data, low-justified, zero-extended |
| mem_req | output | 1 | Memory request, held until ack or error |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Memory access width, same encoding as req_size |
| mem_wdata | output | 32 | Write data on its byte lanes |
| mem_ack | input | 1 | Memory completed the request |
| mem_err | input | 1 | Memory reports an error for the request |
| mem_rdata | input | 32 | Aligned word containing mem_addr |

## Verification
Some properties are checked by assertions on every cycle. Responses are single pulses, and no memory request is made while idle. The bypass state never writes the tag, age or data arrays. A fill keeps its reads inside one aligned line. A fill error produces an immediate zero response. The way that was touched always ends up with the top age value. Other behaviour can only be shown by the bench's scenarios, because it depends on a history of accesses:
- which way is evicted after a pattern of hits and fills;
- that stale cached data survives bypass stores and memory changed behind the cache;
- that a failed fill really leaves the old line missing;
- the exact wrapped order of fill addresses.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BYPASS,
        ST_WRITE,
        ST_LOOK,
        ST_FILL,
        ST_RESP
    } dc_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Move the addressed bytes of a word down to bit 0, zero-extended.
    function automatic logic [31:0] pick_lanes(input logic [31:0] w,
                                               input logic [1:0]  lane,
                                               input logic [1:0]  sz);
        logic [31:0] s;
        s = w >> {lane, 3'b000};
        case (sz)
            SZ_BYTE: pick_lanes = {24'h0, s[7:0]};
            SZ_HALF: pick_lanes = {16'h0, s[15:0]};
            default: pick_lanes = s;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] lane,
                                             input logic [1:0] sz);
        case (sz)
            SZ_BYTE: lane_mask = 4'b0001 << lane;
            SZ_HALF: lane_mask = 4'b0011 << lane;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] place_lanes(input logic [31:0] d,
                                                input logic [1:0]  lane);
        place_lanes = d << {lane, 3'b000};
    endfunction

    function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                                input logic [31:0] new_w,
                                                input logic [3:0]  msk);
        for (int b = 0; b < 4; b++)
            merge_lanes[8*b +: 8] = msk[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    endfunction

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
    parameter int NWAYS = 2,
    parameter int NSETS = 16,
    parameter int TAGW  = 24,
    parameter int SETW  = 4,
    parameter int WAYW  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SETW-1:0] set_i,
    input  logic [TAGW-1:0] tag_i,
    output logic            hit_o,
    output logic [WAYW-1:0] hit_way_o,
    output logic [WAYW-1:0] victim_o,
    input  logic            touch_i,
    input  logic            alloc_i,
    input  logic            inval_i,
    input  logic [WAYW-1:0] way_i
);

    typedef struct packed {
        logic [NSETS-1:0][NWAYS-1:0][TAGW-1:0] tag;
        logic [NSETS-1:0][NWAYS-1:0]           vld;
        logic [NSETS-1:0][NWAYS-1:0][WAYW-1:0] age;
    } tstate_t;

    tstate_t ts_q, ts_d;
    logic [WAYW-1:0] best;

    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (ts_q.vld[set_i][w] && ts_q.tag[set_i][w] == tag_i) begin
                hit_o     = 1'b1;
                hit_way_o = WAYW'(w);
            end
        end

        victim_o = '0;
        best     = ts_q.age[set_i][0];
        for (int w = 1; w < NWAYS; w++) begin
            if (ts_q.age[set_i][w] < best) begin
                best     = ts_q.age[set_i][w];
                victim_o = WAYW'(w);
            end
        end

        ts_d = ts_q;
        if (touch_i) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (WAYW'(w) == way_i)
                    ts_d.age[set_i][w] = WAYW'(NWAYS - 1);
                else if (ts_q.age[set_i][w] != '0)
                    ts_d.age[set_i][w] = ts_q.age[set_i][w] - 1'b1;
            end
        end
        if (alloc_i) begin
            ts_d.tag[set_i][way_i] = tag_i;
            ts_d.vld[set_i][way_i] = 1'b1;
        end
        if (inval_i) begin
            ts_d.vld[set_i][way_i] = 1'b0;
            ts_d.age[set_i][way_i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    // R6
    lru_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> ts_q.age[$past(set_i)][$past(way_i)] == WAYW'(NWAYS - 1));

    // R7
    inval_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_i && $stable(set_i)) |=> !(hit_o && hit_way_o == $past(way_i))
                                        || !$stable(tag_i));

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
    parameter int NWAYS = 2,
    parameter int NSETS = 16,
    parameter int WPL   = 4,
    parameter int SETW  = 4,
    parameter int WAYW  = 1,
    parameter int WOFFW = 2
) (
    input  logic             clk,
    input  logic [SETW-1:0]  set_i,
    input  logic [WAYW-1:0]  way_i,
    input  logic [WOFFW-1:0] word_i,
    output logic [31:0]      rdata_o,
    input  logic             we_i,
    input  logic [31:0]      wdata_i
);

    logic [NSETS-1:0][NWAYS-1:0][WPL-1:0][31:0] arr_q, arr_d;

    always_comb begin
        rdata_o = arr_q[set_i][way_i][word_i];
        arr_d   = arr_q;
        if (we_i) arr_d[set_i][way_i][word_i] = wdata_i;
    end

    always_ff @(posedge clk) arr_q <= arr_d;

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import wt_dcache_pkg::*;
#(
    parameter int NWAYS      = 2,
    parameter int NSETS      = 16,
    parameter int LINE_BYTES = 16,
    parameter int AW         = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cache_present,
    input  logic          cache_enable,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_inhibit,
    input  logic [1:0]    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata
);

    localparam int WPL   = LINE_BYTES / 4;
    localparam int OFFW  = $clog2(LINE_BYTES);
    localparam int WOFFW = OFFW - 2;
    localparam int SETW  = $clog2(NSETS);
    localparam int TAGW  = AW - OFFW - SETW;
    localparam int WAYW  = (NWAYS > 1) ? $clog2(NWAYS) : 1;

    typedef struct packed {
        dc_state_e        st;
        logic             we;
        logic             byp;
        logic [1:0]       size;
        logic [AW-1:0]    addr;
        logic [31:0]      wdata;
        logic [WAYW-1:0]  way;
        logic [WOFFW-1:0] beat;
        logic [31:0]      crit;
        logic [31:0]      rdata;
    } ctl_t;

    ctl_t c_q, c_d;

    logic             tag_hit;
    logic [WAYW-1:0]  hit_way, victim;
    logic             tag_touch, tag_alloc, tag_inval;
    logic [WAYW-1:0]  tag_way;
    logic [WAYW-1:0]  dat_way;
    logic [WOFFW-1:0] dat_word;
    logic             dat_we;
    logic [31:0]      dat_wdata, dat_rdata;
    logic [WOFFW-1:0] fill_word;
    logic [31:0]      crit_word;
    logic [SETW-1:0]  cur_set;
    logic [TAGW-1:0]  cur_tag;

    assign cur_set = c_q.addr[OFFW +: SETW];
    assign cur_tag = c_q.addr[AW-1 -: TAGW];

    dc_tag_store #(
        .NWAYS(NWAYS), .NSETS(NSETS), .TAGW(TAGW), .SETW(SETW), .WAYW(WAYW)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (cur_set),
        .tag_i    (cur_tag),
        .hit_o    (tag_hit),
        .hit_way_o(hit_way),
        .victim_o (victim),
        .touch_i  (tag_touch),
        .alloc_i  (tag_alloc),
        .inval_i  (tag_inval),
        .way_i    (tag_way)
    );

    dc_data_store #(
        .NWAYS(NWAYS), .NSETS(NSETS), .WPL(WPL), .SETW(SETW), .WAYW(WAYW), .WOFFW(WOFFW)
    ) u_data (
        .clk    (clk),
        .set_i  (cur_set),
        .way_i  (dat_way),
        .word_i (dat_word),
        .rdata_o(dat_rdata),
        .we_i   (dat_we),
        .wdata_i(dat_wdata)
    );

    always_comb begin
        c_d       = c_q;
        req_ready = (c_q.st == ST_IDLE);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = c_q.addr;
        mem_size  = c_q.size;
        mem_wdata = place_lanes(c_q.wdata, c_q.addr[1:0]);
        tag_touch = 1'b0;
        tag_alloc = 1'b0;
        tag_inval = 1'b0;
        tag_way   = hit_way;
        dat_way   = hit_way;
        dat_word  = c_q.addr[OFFW-1:2];
        dat_we    = 1'b0;
        dat_wdata = mem_rdata;
        fill_word = c_q.addr[OFFW-1:2] + c_q.beat;
        crit_word = c_q.crit;

        case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.we    = req_write;
                    c_d.size  = req_size;
                    c_d.addr  = req_addr;
                    c_d.wdata = req_wdata;
                    c_d.byp   = !cache_present || !cache_enable || req_inhibit;
                    c_d.rdata = '0;
                    c_d.beat  = '0;
                    if (req_write)   c_d.st = ST_WRITE;
                    else if (c_d.byp) c_d.st = ST_BYPASS;
                    else             c_d.st = ST_LOOK;
                end
            end
            ST_BYPASS: begin
                mem_req = 1'b1;
                if (mem_err) begin
                    c_d.rdata = '0;
                    c_d.st    = ST_RESP;
                end else if (mem_ack) begin
                    c_d.rdata = pick_lanes(mem_rdata, c_q.addr[1:0], c_q.size);
                    c_d.st    = ST_RESP;
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_err)      c_d.st = ST_RESP;
                else if (mem_ack) c_d.st = c_q.byp ? ST_RESP : ST_LOOK;
            end
            ST_LOOK: begin
                if (tag_hit) begin
                    tag_touch = 1'b1;
                    if (c_q.we) begin
                        dat_we    = 1'b1;
                        dat_wdata = merge_lanes(dat_rdata,
                                                place_lanes(c_q.wdata, c_q.addr[1:0]),
                                                lane_mask(c_q.addr[1:0], c_q.size));
                    end else begin
                        c_d.rdata = pick_lanes(dat_rdata, c_q.addr[1:0], c_q.size);
                    end
                    c_d.st = ST_RESP;
                end else begin
                    c_d.way  = victim;
                    c_d.beat = '0;
                    c_d.st   = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {c_q.addr[AW-1:OFFW], fill_word, 2'b00};
                mem_size = SZ_WORD;
                dat_way  = c_q.way;
                dat_word = fill_word;
                tag_way  = c_q.way;
                if (mem_err) begin
                    tag_inval = 1'b1;
                    c_d.rdata = '0;
                    c_d.st    = ST_RESP;
                end else if (mem_ack) begin
                    dat_we    = 1'b1;
                    dat_wdata = mem_rdata;
                    crit_word = (c_q.beat == '0) ? mem_rdata : c_q.crit;
                    c_d.crit  = crit_word;
                    if (c_q.beat == WOFFW'(WPL - 1)) begin
                        tag_alloc = 1'b1;
                        tag_touch = 1'b1;
                        c_d.rdata = c_q.we ? '0
                                           : pick_lanes(crit_word, c_q.addr[1:0], c_q.size);
                        c_d.st    = ST_RESP;
                    end else begin
                        c_d.beat = c_q.beat + 1'b1;
                    end
                end
            end
            ST_RESP: c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsp_valid = (c_q.st == ST_RESP);
    assign rsp_rdata = c_q.rdata;

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    // R7
    fill_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_FILL && mem_req && mem_err) |=> (rsp_valid && rsp_rdata == '0));

    // R5
    fill_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_FILL && $past(c_q.st) == ST_FILL)
            |-> mem_addr[AW-1:OFFW] == $past(mem_addr[AW-1:OFFW]));

    // R2
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_BYPASS) |-> !(tag_touch || tag_alloc || tag_inval || dat_we));

endmodule

// File: tb/tb_wt_dcache.sv
module tb_wt_dcache;
    import wt_dcache_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_present = 1'b1, cache_enable = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_inhibit = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack, mem_err;
    logic [31:0] mem_rdata;

    always #2 clk = ~clk;

    wt_dcache dut (
        .clk(clk), .rst_n(rst_n), .cache_present(cache_present), .cache_enable(cache_enable),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_inhibit(req_inhibit), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata)
    );

    int errors = 0, checks = 0;
    int resp_n = 0, wr_n = 0, err_in = -1;
    logic [1:0]  last_wsize;
    logic [31:0] bmem [256];
    logic [31:0] rd_log [$];

    typedef struct { logic [31:0] v; string rq; } exp_t;
    exp_t sb [$];

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ld(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] w;
        w = bmem[a[9:2]] >> (8 * a[1:0]);
        if (sz == 2'd0) return w & 32'hFF;
        if (sz == 2'd1) return w & 32'hFFFF;
        return w;
    endfunction

    // memory model: answers every request in the cycle after it appears
    initial begin
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
        for (int i = 0; i < 256; i++) bmem[i] = (32'(i) * 32'h0103_0507) ^ 32'hA5C3_0F69;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0; mem_err = 1'b0;
            if (mem_req) begin
                if (err_in == 0) begin
                    mem_err = 1'b1; err_in = -1;
                end else begin
                    if (err_in > 0) err_in--;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        logic [3:0] m;
                        wr_n++; last_wsize = mem_size;
                        m = (mem_size == 2'd0) ? (4'b0001 << mem_addr[1:0]) :
                            (mem_size == 2'd1) ? (4'b0011 << mem_addr[1:0]) : 4'b1111;
                        for (int b = 0; b < 4; b++)
                            if (m[b]) bmem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                    end else begin
                        mem_rdata = bmem[mem_addr[9:2]];
                        rd_log.push_back(mem_addr);
                    end
                end
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (sb.size() == 0) chk(1'b0, "R12 unexpected response", rsp_rdata, 32'h0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rsp_rdata === e.v, e.rq, rsp_rdata, e.v);
                end
                resp_n++;
            end
        end
    end

    task automatic op(input bit we, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] wd, input bit inh, input logic [31:0] exp,
                      input string rq);
        int tgt;
        sb.push_back('{exp, rq});
        rd_log.delete();
        tgt = resp_n + 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_size = sz; req_addr = a;
        req_wdata = wd; req_inhibit = inh;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_inhibit = 1'b0;
        wait (resp_n == tgt);
    endtask

    task automatic ld(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] exp, input string rq);
        op(1'b0, sz, a, 32'h0, 1'b0, exp, rq);
    endtask

    task automatic reads_are(input int n, input string rq);
        chk(rd_log.size() == n, rq, 32'(rd_log.size()), 32'(n));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] old14, oldc, w0;
        int w;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(req_ready === 1'b1, "R12 ready after reset", 32'(req_ready), 32'h1);
        chk(rsp_valid === 1'b0, "R12 no rsp after reset", 32'(rsp_valid), 32'h0);
        chk(mem_req === 1'b0, "R12 no mem_req after reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;

        // R5 wrapped fill from requested word
        ld(2'd2, 32'h14, exp_ld(32'h14, 2'd2), "R5 miss data");
        reads_are(4, "R5 beat count");
        if (rd_log.size() == 4) begin
            chk(rd_log[0] == 32'h14, "R5 beat0", rd_log[0], 32'h14);
            chk(rd_log[1] == 32'h18, "R5 beat1", rd_log[1], 32'h18);
            chk(rd_log[2] == 32'h1C, "R5 beat2", rd_log[2], 32'h1C);
            chk(rd_log[3] == 32'h10, "R5 beat3 wrap", rd_log[3], 32'h10);
        end

        // R3 / R4 widths on hits
        ld(2'd0, 32'h1B, exp_ld(32'h1B, 2'd0), "R3 byte lane3");
        reads_are(0, "R4 hit no reads");
        ld(2'd1, 32'h1A, exp_ld(32'h1A, 2'd1), "R3 half upper");
        ld(2'd1, 32'h18, exp_ld(32'h18, 2'd1), "R3 half lower");
        ld(2'd0, 32'h10, exp_ld(32'h10, 2'd0), "R3 byte lane0");
        reads_are(0, "R4 hit no reads 2");

        // R1 / R6 replacement
        ld(2'd2, 32'h110, exp_ld(32'h110, 2'd2), "R1 second tag");
        reads_are(4, "R1 second tag fills");
        ld(2'd2, 32'h20, exp_ld(32'h20, 2'd2), "R1 other set");
        ld(2'd2, 32'h14, exp_ld(32'h14, 2'd2), "R1 first tag kept");
        reads_are(0, "R1 both ways live");
        ld(2'd2, 32'h210, exp_ld(32'h210, 2'd2), "R6 third tag");
        ld(2'd2, 32'h10, exp_ld(32'h10, 2'd2), "R6 recent kept");
        reads_are(0, "R6 recent way kept");
        ld(2'd2, 32'h110, exp_ld(32'h110, 2'd2), "R6 older evicted");
        reads_are(4, "R6 older way evicted");

        // R2 bypass paths
        old14 = bmem[5];
        bmem[5] = 32'h1234_5678;
        op(1'b0, 2'd2, 32'h14, 0, 1'b1, 32'h1234_5678, "R2 inhibit load");
        reads_are(1, "R2 inhibit one read");
        ld(2'd2, 32'h14, old14, "R2 cache untouched");
        reads_are(0, "R2 still hit");
        cache_enable = 1'b0;
        ld(2'd0, 32'h31, exp_ld(32'h31, 2'd0), "R2 disabled byte");
        reads_are(1, "R2 disabled one read");
        cache_enable = 1'b1;
        bmem[12] = 32'hCAFE_0001;
        ld(2'd2, 32'h30, 32'hCAFE_0001, "R2 no allocation");
        reads_are(4, "R2 no allocation fill");
        cache_present = 1'b0;
        ld(2'd2, 32'h14, 32'h1234_5678, "R2 absent load");
        cache_present = 1'b1;

        // R8 / R9 store hit
        w = wr_n;
        op(1'b1, 2'd0, 32'h13, 32'hEE, 1'b0, 32'h0, "R12 store rsp");
        chk(wr_n == w + 1, "R8 one write", 32'(wr_n - w), 32'h1);
        chk(last_wsize == 2'd0, "R8 byte size", 32'(last_wsize), 32'h0);
        chk(bmem[4][31:24] == 8'hEE, "R8 memory lane", 32'(bmem[4][31:24]), 32'hEE);
        reads_are(0, "R9 hit no fill");
        ld(2'd2, 32'h10, bmem[4], "R9 merged word");
        reads_are(0, "R9 served from cache");
        op(1'b1, 2'd1, 32'h1E, 32'h7788, 1'b0, 32'h0, "R8 half store");
        chk(last_wsize == 2'd1, "R8 half size", 32'(last_wsize), 32'h1);
        ld(2'd2, 32'h1C, bmem[7], "R9 merged half");

        // R10 store miss allocates
        w = wr_n;
        op(1'b1, 2'd1, 32'h42, 32'hBEEF, 1'b0, 32'h0, "R10 store miss rsp");
        chk(wr_n == w + 1, "R10 write first", 32'(wr_n - w), 32'h1);
        reads_are(4, "R10 allocating fill");
        ld(2'd2, 32'h40, bmem[16], "R10 allocated data");
        reads_are(0, "R10 line present");

        // R11 bypassed store and failed store
        oldc = bmem[6];
        op(1'b1, 2'd2, 32'h18, 32'hDEAD_BEEF, 1'b1, 32'h0, "R11 inhibit store rsp");
        chk(bmem[6] == 32'hDEAD_BEEF, "R11 memory written", bmem[6], 32'hDEAD_BEEF);
        ld(2'd2, 32'h18, oldc, "R11 cache unchanged by bypass");
        reads_are(0, "R11 still hit");
        w0 = bmem[4];
        err_in = 0;
        op(1'b1, 2'd2, 32'h10, 32'h55AA_55AA, 1'b0, 32'h0, "R11 failed store rsp");
        chk(bmem[4] == w0, "R11 memory not written", bmem[4], w0);
        ld(2'd2, 32'h10, w0, "R11 cache unchanged by error");
        reads_are(0, "R11 no lookup fill");

        // R7 fill error invalidates victim (way holding 0x110)
        err_in = 1;
        ld(2'd2, 32'h310, 32'h0, "R7 error data zero");
        reads_are(1, "R7 fill aborted");
        ld(2'd2, 32'h110, exp_ld(32'h110, 2'd2), "R7 victim invalidated");
        reads_are(4, "R7 victim refilled");
        ld(2'd2, 32'h10, w0, "R7 other way intact");
        reads_are(0, "R7 other way hit");

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R12 every request answered", 32'(sb.size()), 32'h0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule